// File: doc/BRIEF.md
# Cascadable Nibble-Packed Segment Line Loader

This block gathers one display line of segment data into an 80-bit first-stage register. A display controller presents the data on a slow shift clock. In parallel mode each falling edge of that clock delivers a 4-bit word. In serial mode each falling edge delivers a single bit, and the block packs those bits into 4-bit words. The register is always written one whole 4-bit slot at a time. An address counter walks through the 20 slots in ascending order, starting from the lowest bit positions.

Several loaders can be chained so that one long serial line spreads across them. Each device accepts data only while its chain-disable input is low. Its chain output stays high while it is still filling. That output drops low once the last slot has been written, which enables the next device in the chain. A falling edge on the line strobe re-arms the device for the next line: it rewinds the slot counter, empties the serial packer and raises the chain output again. The strobe does not clear the register contents.

The block runs on a fast system clock. The shift clock and the strobe are synchronised over two flops and their falling edges are detected. A two-state machine controls the flow. In ST_FILL the device accepts data. The transition FILL_TO_FULL fires on the write of the last slot and moves to ST_FULL, where shift-clock edges are ignored. The transition FULL_TO_FILL fires on a strobe falling edge. A strobe falling edge that arrives while in ST_FILL (REARM_IN_FILL) keeps the state but still rewinds the counter and the packer.

Top module: `seg_line_loader`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released with no further stimulus, `line_q_o` is all zeros and `next_dis_o` is high.
- R2: With `par_mode_i` high, each accepted shift-clock falling edge writes `data_i[3:0]` into one slot. `data_i[0]` goes to the lowest bit of the slot and `data_i[3]` to the highest.
- R3: With `par_mode_i` low, each accepted edge takes one bit from `data_i[0]` and `data_i[3:1]` are ignored. Within a slot, the first bit received lands in the lowest bit position.
- R4: In serial mode the register changes only when the fourth bit of a slot arrives. While one to three bits are pending, `line_q_o` is unchanged.
- R5: After reset or a strobe, the first slot written is bits [3:0]. Each following slot is the next higher group of 4 bits: slot k holds bits [4k+3:4k].
- R6: While `chain_dis_i` is high, shift-clock edges leave `line_q_o`, the slot counter and the serial packer unchanged.
- R7: `next_dis_o` stays high until the 20th slot is written. It falls in the same system-clock cycle in which that slot appears on `line_q_o`.
- R8: Once `next_dis_o` is low, further shift-clock edges leave `line_q_o` unchanged, even with `chain_dis_i` low, until a strobe falling edge.
- R9: A falling edge on `line_strobe_i` raises `next_dis_o`, rewinds writing to slot 0 and discards pending serial bits. `line_q_o` keeps its contents.
- R10: A shift-clock falling edge shows up on `line_q_o` at the third rising edge of `clk` after the input changes. The data, mode and chain-disable values used are the ones present when the shift clock fell.
- R11: If the strobe and the shift clock fall in the same synchronised cycle, the strobe takes effect and that shift-clock edge writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk_i | input | 1 | Shift clock; data is taken on its falling edge |
| line_strobe_i | input | 1 | Line strobe; a falling edge re-arms for a new line |
| par_mode_i | input | 1 | High: 4-bit parallel words; low: serial bits on data_i[0] |
| chain_dis_i | input | 1 | Chain disable; data is accepted only while low |
| data_i | input | 4 | Data input; bit 0 is the serial input |
| next_dis_o | output | 1 | Chain output to the next device; high while filling, low when full |
| line_q_o | output | 80 | First-stage line register, slot k at bits [4k+3:4k] |

## Verification
The hardest situation to reach from the ports is a strobe falling edge that lands in the same synchronised cycle as a shift-clock falling edge. The bench produces it by driving both inputs low on the same system-clock falling edge, so both pass through identical synchroniser depths. The bench then shows that the next word goes into slot 0. A second hard case is a serial line that is abandoned partway through a slot. The bench sends two bits, issues a strobe, then sends a full slot and confirms that none of the stale bits appear. A cycle-accurate behavioural model in the bench follows every system clock through parallel and serial fills, gating by chain disable, and edges after the device is full.

// File: rtl/seg_pkg.sv
package seg_pkg;

    // Fill-control states of the line loader.
    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;

endpackage

// File: rtl/seg_fall_detect.sv
// Synchronises a slow strobe into clk and flags its falling edge for one cycle.
module seg_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin_i};
        end
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

    // The pulse never lasts two cycles in a row.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/seg_delay_pipe.sv
// Delays side-band inputs by the synchroniser depth so they line up with the edge pulse.
module seg_delay_pipe #(
    parameter int             W       = 6,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    stage_q[g] <= din_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout_o = stage_q[STAGES-1];

endmodule

// File: rtl/seg_nibble_packer.sv
// Collects serial bits into a word; the word is presented when its last bit arrives.
module seg_nibble_packer #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic             bit_i,
    output logic             nib_vld_o,
    output logic [NIB_W-1:0] nib_o
);
    localparam int CW = $clog2(NIB_W);

    logic [CW-1:0]    fill_q;
    logic [NIB_W-2:0] held_q;
    logic             last_bit;

    assign last_bit  = (fill_q == CW'(NIB_W-1));
    assign nib_vld_o = take_i && last_bit;
    assign nib_o     = {bit_i, held_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            held_q <= '0;
        end else if (clear_i) begin
            fill_q <= '0;
        end else if (take_i) begin
            for (int i = 0; i < NIB_W-1; i++) begin
                if (fill_q == CW'(i)) held_q[i] <= bit_i;
            end
            fill_q <= last_bit ? '0 : fill_q + CW'(1);
        end
    end

    // A clear always leaves the packer empty.
    p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (fill_q == '0));

endmodule

// File: rtl/seg_slot_store.sv
// Slot address counter, write decode and the first-stage line register.
module seg_slot_store #(
    parameter int LINE_BITS = 80,
    parameter int NIB_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 wr_i,
    input  logic [NIB_W-1:0]     nib_i,
    output logic [LINE_BITS-1:0] line_o,
    output logic                 last_o
);
    localparam int SLOTS  = LINE_BITS / NIB_W;
    localparam int ADDR_W = $clog2(LINE_BITS);

    logic [ADDR_W-1:0] addr_q;
    logic [SLOTS-1:0]  we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (clear_i) begin
            addr_q <= '0;
        end else if (wr_i) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign last_o = wr_i && (addr_q == ADDR_W'(SLOTS-1));

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic [NIB_W-1:0] cell_q;
            assign we[s] = wr_i && (addr_q == ADDR_W'(s));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q <= '0;
                end else if (we[s]) begin
                    cell_q <= nib_i;
                end
            end
            assign line_o[s*NIB_W +: NIB_W] = cell_q;
        end
    endgenerate

    // The controller never asks for a write past the final slot.
    p_no_write_past_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (addr_q < ADDR_W'(SLOTS)));

    // Slots are taken in strictly ascending order.
    p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clear_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

endmodule

// File: rtl/seg_line_loader.sv
// Cascadable line loader: synchronisers, fill control FSM, packer and slot store.
module seg_line_loader
    import seg_pkg::*;
#(
    parameter int LINE_BITS   = 80,
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_clk_i,
    input  logic                 line_strobe_i,
    input  logic                 par_mode_i,
    input  logic                 chain_dis_i,
    input  logic [NIB_W-1:0]     data_i,
    output logic                 next_dis_o,
    output logic [LINE_BITS-1:0] line_q_o
);
    localparam int SIDE_W = NIB_W + 2;

    fill_state_t       state_q, state_d;
    logic              cp_fall, ld_fall;
    logic [SIDE_W-1:0] side_d;
    logic              mode_d, cdi_d;
    logic [NIB_W-1:0]  data_d;
    logic              take, par_wr, ser_take, ser_vld, wr, last;
    logic [NIB_W-1:0]  ser_nib, wr_nib;

    seg_fall_detect #(.STAGES(SYNC_STAGES)) u_cp_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(shift_clk_i), .fall_o(cp_fall));

    seg_fall_detect #(.STAGES(SYNC_STAGES)) u_ld_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(line_strobe_i), .fall_o(ld_fall));

    seg_delay_pipe #(
        .W(SIDE_W), .STAGES(SYNC_STAGES),
        .RST_VAL({1'b0, 1'b1, {NIB_W{1'b0}}})
    ) u_side (
        .clk(clk), .rst_n(rst_n),
        .din_i({par_mode_i, chain_dis_i, data_i}),
        .dout_o(side_d));

    assign {mode_d, cdi_d, data_d} = side_d;

    // Accept only in FILL, while enabled, and never in a strobe cycle.
    assign take     = cp_fall && !ld_fall && (state_q == ST_FILL) && !cdi_d;
    assign par_wr   = take && mode_d;
    assign ser_take = take && !mode_d;

    seg_nibble_packer #(.NIB_W(NIB_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear_i(ld_fall), .take_i(ser_take),
        .bit_i(data_d[0]), .nib_vld_o(ser_vld), .nib_o(ser_nib));

    assign wr     = par_wr || ser_vld;
    assign wr_nib = mode_d ? data_d : ser_nib;

    seg_slot_store #(.LINE_BITS(LINE_BITS), .NIB_W(NIB_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(ld_fall), .wr_i(wr),
        .nib_i(wr_nib), .line_o(line_q_o), .last_o(last));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        next_dis_o = 1'b1;
        unique case (state_q)
            ST_FILL: begin
                next_dis_o = 1'b1;
                if (!ld_fall && last) state_d = ST_FULL;   // FILL_TO_FULL
            end
            ST_FULL: begin
                next_dis_o = 1'b0;
                if (ld_fall) state_d = ST_FILL;            // FULL_TO_FILL
            end
        endcase
    end

    p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cdi_d |=> $stable(line_q_o));

    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |=> $stable(line_q_o));

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fall |=> next_dis_o);

    p_partial_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_take && !ser_vld) |=> $stable(line_q_o));

    p_strobe_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fall |=> $stable(line_q_o));

    p_fall_on_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(next_dis_o) |-> $past(wr));

endmodule

// File: tb/sim_seg_line_loader.sv
module sim_seg_line_loader;
    localparam int LB = 80;
    localparam int NW = 4;
    localparam int SL = LB / NW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cp, ld, md, cdi;
    logic [NW-1:0] d;
    logic          next_dis;
    logic [LB-1:0] line;

    always #10 clk = ~clk;   // 50 MHz

    seg_line_loader u0 (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(cp), .line_strobe_i(ld),
        .par_mode_i(md), .chain_dis_i(cdi), .data_i(d),
        .next_dis_o(next_dis), .line_q_o(line));

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic cp, ld, md, cdi;
        logic [NW-1:0] d;
    } smp_t;
    smp_t          hq[$];
    logic [LB-1:0] m_line;
    int            m_cnt, m_nb;
    logic [NW-1:0] m_acc;
    bit            m_full;

    always @(posedge clk) begin
        smp_t cur, a, b;
        bit cpf, ldf;
        if (!rst_n) begin
            m_line = '0; m_cnt = 0; m_nb = 0; m_acc = '0; m_full = 0;
            hq.delete();
            for (int i = 0; i < 3; i++) hq.push_back('{1'b1, 1'b1, 1'b0, 1'b1, 4'h0});
        end else begin
            cur = '{cp, ld, md, cdi, d};
            hq.push_front(cur);
            while (hq.size() > 4) void'(hq.pop_back());
            a = hq[2]; b = hq[3];
            cpf = b.cp && !a.cp;
            ldf = b.ld && !a.ld;
            if (ldf) begin
                m_cnt = 0; m_nb = 0; m_full = 0;
            end else if (cpf && !m_full && !a.cdi) begin
                if (a.md) begin
                    m_line[m_cnt*NW +: NW] = a.d;
                    m_cnt++;
                end else begin
                    m_acc[m_nb] = a.d[0];
                    m_nb++;
                    if (m_nb == NW) begin
                        m_line[m_cnt*NW +: NW] = m_acc;
                        m_cnt++;
                        m_nb = 0;
                    end
                end
                if (m_cnt == SL) m_full = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [LB-1:0] act, input logic [LB-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 model line", line, m_line);
            chk("R7 model chain", {{(LB-1){1'b0}}, next_dis}, {{(LB-1){1'b0}}, !m_full});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_fail++;
            $display("FAIL R1 watchdog act=timeout exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cp_edge(input logic [NW-1:0] v);
        @(negedge clk) d = v;
        repeat (3) @(negedge clk);
        cp = 1'b0;
        repeat (4) @(negedge clk);
        cp = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk) ld = 1'b0;
        repeat (4) @(negedge clk);
        ld = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [NW-1:0] pat(input int k);
        return NW'(k * 5 + 3);
    endfunction

    logic [LB-1:0] e_line;
    logic [LB-1:0] one_bit;

    initial begin
        rst_n = 1'b0; cp = 1'b1; ld = 1'b1; md = 1'b0; cdi = 1'b1; d = '0;
        e_line = '0;
        one_bit = '0;
        repeat (5) @(negedge clk);
        chk("R1 line in reset", line, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 line after reset", line, '0);
        one_bit = LB'(next_dis);
        chk("R1 chain high", one_bit, LB'(1));

        // R2 / R5 / R7: parallel fill
        md = 1'b1; cdi = 1'b0;
        for (int k = 0; k < SL; k++) begin
            cp_edge(pat(k));
            e_line[k*NW +: NW] = pat(k);
            if (k == SL-2) chk("R7 still high at 19 slots", LB'(next_dis), LB'(1));
        end
        chk("R2 parallel line", line, e_line);
        chk("R5 first slot low", LB'(line[3:0]), LB'(pat(0)));
        chk("R7 chain low when full", LB'(next_dis), LB'(0));

        // R8: edges after full ignored
        cp_edge(4'hF);
        cp_edge(4'h0);
        chk("R8 full ignores edges", line, e_line);

        // R9: strobe re-arms, contents kept
        strobe();
        chk("R9 chain high after strobe", LB'(next_dis), LB'(1));
        chk("R9 contents kept", line, e_line);
        cp_edge(4'hA);
        e_line[3:0] = 4'hA;
        chk("R9 rewind to slot 0", line, e_line);

        // R6: chain disable gates capture
        cdi = 1'b1;
        cp_edge(4'h5);
        cp_edge(4'h6);
        chk("R6 disabled edges ignored", line, e_line);
        cdi = 1'b0;
        cp_edge(4'h3);
        e_line[7:4] = 4'h3;
        chk("R6 counter held while disabled", line, e_line);

        // R10: latency of three system clocks
        @(negedge clk) d = 4'hC;
        repeat (3) @(negedge clk);
        cp = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 unchanged after two clocks", line, e_line);
        @(negedge clk);
        e_line[11:8] = 4'hC;
        chk("R10 written at third clock", line, e_line);
        repeat (3) @(negedge clk);
        cp = 1'b1;
        repeat (4) @(negedge clk);

        // R11: strobe and shift clock fall together
        @(negedge clk) d = 4'h9;
        repeat (3) @(negedge clk);
        cp = 1'b0; ld = 1'b0;
        repeat (4) @(negedge clk);
        cp = 1'b1; ld = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 coincident edge writes nothing", line, e_line);
        cp_edge(4'h7);
        e_line[3:0] = 4'h7;
        chk("R11 strobe rewound counter", line, e_line);

        // R3 / R4: serial packing
        strobe();
        md = 1'b0;
        cp_edge(4'b1111);
        cp_edge(4'b1110);
        cp_edge(4'b1111);
        chk("R4 partial slot not written", line, e_line);
        cp_edge(4'b0101);
        e_line[3:0] = 4'b1101;
        chk("R3 serial bit order", line, e_line);

        // R9: pending serial bits dropped by strobe
        strobe();
        cp_edge(4'b0001);
        cp_edge(4'b0001);
        strobe();
        cp_edge(4'b0000);
        cp_edge(4'b0001);
        cp_edge(4'b0001);
        cp_edge(4'b0000);
        e_line[3:0] = 4'b0110;
        chk("R9 stale serial bits dropped", line, e_line);

        // R7 / R3: fill the rest serially
        for (int i = 0; i < LB - NW; i++) begin
            cp_edge((i % 3 == 0) ? 4'b1000 : 4'b0111);
            e_line[NW + i] = (i % 3 == 0) ? 1'b0 : 1'b1;
        end
        chk("R3 serial full line", line, e_line);
        chk("R7 chain low after serial fill", LB'(next_dis), LB'(0));
        cp_edge(4'b0001);
        chk("R8 serial edge after full", line, e_line);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule